// File: doc/BRIEF.md
# Tap-Select Serial Input Phase Aligner

This block sits behind a low-speed serial input lane. A delay line, modelled here as a 15-bit vector, samples each incoming bit at 15 evenly spaced taps that together span up to 7/4 of a bit period. Every clock the aligner picks one tap as the sampling point. It outputs the bit seen at that tap together with the tap index in use.

Three alignment modes are available. In static mode the tap comes straight from a configuration input. In automatic mode the block finds the data transition inside the sample vector and places the sampling tap half a bit away from it. Before lock the search is held to taps 4 through 11. Once the block has locked, the tap may wander only three taps either side of the tap it locked on. In trained mode the same tracking runs only while a train strobe is high. The tap is frozen when the strobe falls, and a new strobe starts a fresh search. Placement depends on transitions, so lock needs data that toggles often enough.

Top module: `serial_phase_aligner`

## Requirements
- R1: While reset is high and in the first cycle after it, tap_out is 0, locked is 0 and data_out is 0.
- R2: Mode code 0 or 3 selects static mode. In this mode tap_out takes the value of static_tap one cycle later, and a static_tap of 15 is limited to 14.
- R3: data_out equals the sample bit at index tap_out, one cycle after that sample vector is presented.
- R4: The edge position is the lowest index i (0..13) for which sample bit i differs from bit i+1. The raw target tap is i+4 when that value is at most 14, and i-4 otherwise.
- R5: In automatic mode (code 1), each vector that contains a transition moves tap_out on the next cycle to the raw target, limited to the range 4..11.
- R6: A vector with no transition (all bits equal) leaves tap_out unchanged and does not advance or restart lock qualification.
- R7: The locked output rises on the transition that completes 16 consecutive qualifying transitions. A transition qualifies when it lies within one tap of the previous transition. A transition farther away restarts the count at one.
- R8: While locked and the mode is unchanged, locked stays high. Every later tap is also limited to the anchor tap (the tap chosen on the locking transition) plus or minus 3, inside the range 4..11.
- R9: In trained mode (code 2) the tap tracks as in automatic mode while train is high. It holds its value while train is low. A rising train edge clears the lock state and starts a new search.
- R10: A change of the mode input clears locked and the qualification count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample vector per cycle |
| rst | input | 1 | Synchronous active-high reset |
| samples | input | 15 | Samples of the current bit taken at taps 0..14 |
| mode | input | 2 | 0/3 static, 1 automatic, 2 trained |
| static_tap | input | 4 | Tap used in static mode |
| train | input | 1 | Training strobe for trained mode |
| data_out | output | 1 | Recovered bit at the selected tap |
| tap_out | output | 4 | Tap index in use |
| locked | output | 1 | Lock flag |

## Verification
The bench builds the block with its default parameters: 15 taps, a half-bit offset of 4, a window of 4..11, a drift bound of 3 and a lock count of 16. With these values, single transitions near either end of the line exercise the wrap of the offset and both window clamps. A locked anchor of 7 puts both drift limits (4 and 10) next to the window limits, so targets of 13 and 4 test the drift bound against the window bound. A 16-transition count is short enough to show the locking transition itself, a broken run, and qualification with one tap of jitter.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    MODE_STATIC     = 2'd0,
    MODE_AUTO       = 2'd1,
    MODE_TRAIN      = 2'd2,
    MODE_STATIC_ALT = 2'd3
  } pa_mode_e;
endpackage

// File: rtl/pa_edge_finder.sv
module pa_edge_finder #(
  parameter int NTAPS = 15,
  parameter int TAP_W = $clog2(NTAPS)
) (
  input  logic [NTAPS-1:0] samples,
  output logic             edge_valid,
  output logic [TAP_W-1:0] edge_pos
);
  // lowest transition index wins: scan from the top down
  always_comb begin
    edge_valid = 1'b0;
    edge_pos   = '0;
    for (int i = NTAPS - 2; i >= 0; i--) begin
      if (samples[i] ^ samples[i+1]) begin
        edge_valid = 1'b1;
        edge_pos   = TAP_W'(i);
      end
    end
  end
endmodule

// File: rtl/pa_tap_target.sv
module pa_tap_target #(
  parameter int NTAPS     = 15,
  parameter int TAP_W     = $clog2(NTAPS),
  parameter int HALF_TAPS = 4,
  parameter int WIN_LO    = 4,
  parameter int WIN_HI    = 11,
  parameter int DRIFT     = 3
) (
  input  logic [TAP_W-1:0] edge_pos,
  input  logic             bound_en,
  input  logic [TAP_W-1:0] anchor,
  output logic [TAP_W-1:0] tap
);
  int t, lo, hi;

  always_comb begin
    t = int'(edge_pos) + HALF_TAPS;
    if (t > NTAPS - 1) t = int'(edge_pos) - HALF_TAPS;
    if (t < 0) t = 0;
    lo = WIN_LO;
    hi = WIN_HI;
    if (bound_en) begin
      if (int'(anchor) - DRIFT > lo) lo = int'(anchor) - DRIFT;
      if (int'(anchor) + DRIFT < hi) hi = int'(anchor) + DRIFT;
    end
    if (t < lo) t = lo;
    if (t > hi) t = hi;
    tap = TAP_W'(t);
  end
endmodule

// File: rtl/pa_lock_tracker.sv
module pa_lock_tracker #(
  parameter int TAP_W      = 4,
  parameter int LOCK_EDGES = 16,
  parameter int CNT_W      = $clog2(LOCK_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             enable,
  input  logic             edge_valid,
  input  logic [TAP_W-1:0] edge_pos,
  input  logic [TAP_W-1:0] new_tap,
  output logic             locked,
  output logic [TAP_W-1:0] anchor
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_EDGES);

  logic             have_ref;
  logic [TAP_W-1:0] ref_pos;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             near;

  always_comb begin
    near = have_ref &&
           ((edge_pos >= ref_pos) ? (edge_pos - ref_pos <= TAP_W'(1))
                                  : (ref_pos - edge_pos <= TAP_W'(1)));
    if (!near)               cnt_nxt = CNT_W'(1);
    else if (cnt < CNT_MAX)  cnt_nxt = cnt + CNT_W'(1);
    else                     cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      have_ref <= 1'b0;
      ref_pos  <= '0;
      cnt      <= '0;
      locked   <= 1'b0;
      anchor   <= '0;
    end else if (enable && edge_valid) begin
      have_ref <= 1'b1;
      ref_pos  <= edge_pos;
      cnt      <= cnt_nxt;
      if (!locked && cnt_nxt == CNT_MAX) begin
        locked <= 1'b1;
        anchor <= new_tap;
      end
    end
  end
endmodule

// File: rtl/serial_phase_aligner.sv
module serial_phase_aligner #(
  parameter int NTAPS      = 15,
  parameter int HALF_TAPS  = 4,
  parameter int WIN_LO     = 4,
  parameter int WIN_HI     = 11,
  parameter int DRIFT      = 3,
  parameter int LOCK_EDGES = 16,
  localparam int TAP_W     = $clog2(NTAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTAPS-1:0] samples,
  input  logic [1:0]       mode,
  input  logic [TAP_W-1:0] static_tap,
  input  logic             train,
  output logic             data_out,
  output logic [TAP_W-1:0] tap_out,
  output logic             locked
);
  import pa_pkg::*;

  localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(NTAPS - 1);

  pa_mode_e         mode_e, mode_q;
  logic             train_q;
  logic             is_static, tracking, clear;
  logic             edge_valid;
  logic [TAP_W-1:0] edge_pos, target, anchor, tap_q, static_lim;

  assign mode_e    = pa_mode_e'(mode);
  assign is_static = (mode_e == MODE_STATIC) || (mode_e == MODE_STATIC_ALT);
  assign tracking  = (mode_e == MODE_AUTO) || (mode_e == MODE_TRAIN && train);
  assign clear     = is_static || (mode_e != mode_q) ||
                     (mode_e == MODE_TRAIN && train && !train_q);
  assign static_lim = (static_tap > TAP_MAX) ? TAP_MAX : static_tap;

  pa_edge_finder #(.NTAPS(NTAPS), .TAP_W(TAP_W)) u_edge (
    .samples    (samples),
    .edge_valid (edge_valid),
    .edge_pos   (edge_pos)
  );

  pa_tap_target #(
    .NTAPS(NTAPS), .TAP_W(TAP_W), .HALF_TAPS(HALF_TAPS),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .DRIFT(DRIFT)
  ) u_target (
    .edge_pos (edge_pos),
    .bound_en (locked && !clear),
    .anchor   (anchor),
    .tap      (target)
  );

  pa_lock_tracker #(.TAP_W(TAP_W), .LOCK_EDGES(LOCK_EDGES)) u_lock (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .enable     (tracking),
    .edge_valid (edge_valid),
    .edge_pos   (edge_pos),
    .new_tap    (target),
    .locked     (locked),
    .anchor     (anchor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_STATIC;
      train_q  <= 1'b0;
      tap_q    <= '0;
      data_out <= 1'b0;
    end else begin
      mode_q   <= mode_e;
      train_q  <= train;
      data_out <= samples[tap_q];
      if (is_static)                    tap_q <= static_lim;
      else if (tracking && edge_valid)  tap_q <= target;
    end
  end

  assign tap_out = tap_q;
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int NTAPS  = 15,
  parameter int WIN_LO = 4,
  parameter int WIN_HI = 11,
  parameter int DRIFT  = 3,
  localparam int TAP_W = $clog2(NTAPS)
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [TAP_W-1:0] static_tap,
  input logic             train,
  input logic [TAP_W-1:0] tap_out,
  input logic             locked,
  input logic             edge_valid,
  input logic [TAP_W-1:0] anchor
);
  assert_tap_range_R2: assert property (@(posedge clk) disable iff (rst)
    int'(tap_out) <= NTAPS - 1);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tap_out == '0 && !locked));

  assert_static_follow_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 2'd0 || $past(mode) == 2'd3)) |->
      (int'(tap_out) == ((int'($past(static_tap)) > NTAPS - 1) ? NTAPS - 1
                                                               : int'($past(static_tap)))));

  assert_auto_window_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == 2'd1 && $past(edge_valid)) |->
      (int'(tap_out) >= WIN_LO && int'(tap_out) <= WIN_HI));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (locked && mode == 2'd1 && mode == $past(mode)) |=> locked);

  assert_drift_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && locked && $past(locked) && $past(mode) == 2'd1 && $past(edge_valid)) |->
      (int'(tap_out) >= int'(anchor) - DRIFT && int'(tap_out) <= int'(anchor) + DRIFT));

  assert_train_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode == 2'd2 && $past(mode) == 2'd2 && !$past(train)) |->
      $stable(tap_out));
endmodule

bind serial_phase_aligner pa_checker #(
  .NTAPS(NTAPS), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .DRIFT(DRIFT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .static_tap (static_tap),
  .train      (train),
  .tap_out    (tap_out),
  .locked     (locked),
  .edge_valid (edge_valid),
  .anchor     (anchor)
);

// File: tb/serial_phase_aligner_tb_top.sv
`timescale 1ns/1ps
module serial_phase_aligner_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [14:0] samples = '0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  static_tap = '0;
  logic        train = 1'b0;
  logic        data_out;
  logic [3:0]  tap_out;
  logic        locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_phase_aligner dut_i (
    .clk(clk), .rst(rst), .samples(samples), .mode(mode),
    .static_tap(static_tap), .train(train),
    .data_out(data_out), .tap_out(tap_out), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // transition between index e and e+1
  function automatic logic [14:0] edge_vec(input int e, input bit pol);
    logic [14:0] v;
    for (int i = 0; i < 15; i++) v[i] = (i <= e) ? pol : ~pol;
    return v;
  endfunction

  task automatic step(input logic [14:0] v);
    @(negedge clk);
    samples = v;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mode = 2'd0; train = 1'b0; static_tap = '0; samples = '0;
    @(posedge clk); #1;
    chk("R1 tap in reset", tap_out, 0);
    chk("R1 locked in reset", locked, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 tap after reset", tap_out, 0);
    chk("R1 data after reset", data_out, 0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m; samples = '0;
    @(posedge clk); #1;
  endtask

  task automatic t_static();
    do_reset();
    @(negedge clk); static_tap = 4'd13;
    step(15'h0000);
    chk("R2 static tap 13", tap_out, 13);
    step(15'h2000);
    chk("R3 data at tap 13 high", data_out, 1);
    step(15'h5FFF);
    chk("R3 data at tap 13 low", data_out, 0);
    @(negedge clk); static_tap = 4'd15; mode = 2'd3;
    step(15'h4000);
    chk("R2 static tap 15 limited", tap_out, 14);
    step(15'h0000);
    chk("R3 data at tap 14", data_out, 0);
  endtask

  task automatic t_window();
    do_reset();
    set_mode(2'd1);
    step(edge_vec(10, 0)); chk("R5 e10 -> clamp 11", tap_out, 11);
    step(edge_vec(12, 1)); chk("R4 e12 wraps to 8", tap_out, 8);
    step(edge_vec(0, 0));  chk("R5 e0 -> 4", tap_out, 4);
    step(edge_vec(13, 1)); chk("R4 e13 wraps to 9", tap_out, 9);
    step(15'h7FFF);        chk("R6 no transition holds tap", tap_out, 9);
  endtask

  task automatic t_lock();
    do_reset();
    set_mode(2'd1);
    for (int i = 0; i < 15; i++) begin
      step(edge_vec(3, i[0]));
      if (i == 7) step(15'h0000); // idle vector in the middle of the run
    end
    chk("R7 not locked after 15", locked, 0);
    chk("R5 tap from e3", tap_out, 7);
    step(edge_vec(3, 1));
    chk("R7 locked on 16th", locked, 1);
    step(edge_vec(9, 0));
    chk("R8 drift caps at 10", tap_out, 10);
    chk("R8 lock sticky after far edge", locked, 1);
    step(edge_vec(0, 1));
    chk("R8 lower drift bound 4", tap_out, 4);
    step(15'h0000);
    chk("R6 tap unchanged", tap_out, 4);
    set_mode(2'd0);
    chk("R10 mode change clears lock", locked, 0);
  endtask

  task automatic t_consecutive();
    do_reset();
    set_mode(2'd1);
    for (int i = 0; i < 10; i++) step(edge_vec(3, i[0]));
    step(edge_vec(8, 0));
    chk("R5 e8 clamps to 11", tap_out, 11);
    for (int i = 0; i < 14; i++) step(edge_vec(8, ~i[0]));
    chk("R7 restarted run not yet locked", locked, 0);
    step(edge_vec(8, 0));
    chk("R7 locked after restarted run", locked, 1);
    do_reset();
    set_mode(2'd1);
    for (int i = 0; i < 16; i++) step(edge_vec(3 + (i % 2), i[0]));
    chk("R7 locked with one-tap jitter", locked, 1);
    chk("R4 tap from e4", tap_out, 8);
  endtask

  task automatic t_train();
    do_reset();
    @(negedge clk); mode = 2'd2; train = 1'b1; samples = '0;
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) step(edge_vec(5, i[0]));
    chk("R9 tracks while training", tap_out, 9);
    @(negedge clk); train = 1'b0;
    for (int i = 0; i < 3; i++) step(edge_vec(0, i[0]));
    chk("R9 frozen after strobe falls", tap_out, 9);
    @(negedge clk); train = 1'b1;
    step(15'h0000);
    step(edge_vec(0, 1));
    chk("R9 retrain moves tap", tap_out, 4);
    chk("R9 retrain cleared lock", locked, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_static();
    t_window();
    t_lock();
    t_consecutive();
    t_train();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule